// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two parallel buses, called A and B, in both directions. Each direction has its own storage register, capture strobe, source select and output enable. The data path is cut into independent byte sections, and every section has its own copy of all six controls. A direction drives the opposite bus either with the live value seen on its source bus or with the value held in its register. Nothing is inverted on the way.

Each bus bit is split into an external input value, an external driver-present flag, an internal output value and an internal output enable, so the block can be synthesized. The value seen on a bus bit is resolved from three sources: an external driver, the block's own stored drive, or a live drive from the far bus. If none of these is active, a bus keeper supplies the bit's last value. Everything runs on one system clock. The two direction clocks are modelled as single-cycle capture strobes.

Capture does not depend on the selects or enables. The two enables have opposite polarities. When both directions are enabled in live mode, the two buses hold each other's value without using the registers.

Top module: `xcvr_regbus`

## Requirements
- R1: When `a_cap` of a section is 1 at a rising clock edge, the A register of that section loads the A-bus value seen in that cycle, whatever the selects and enables are. Otherwise the register keeps its value.
- R2: When `b_cap` of a section is 1 at a rising clock edge, the B register of that section loads the B-bus value seen in that cycle, whatever the selects and enables are.
- R3: `b_out` equals the A-bus value seen in the same cycle when `b_src_reg`=0, and equals the A register when `b_src_reg`=1. `a_out` is formed the same way from the B bus, the B register and `a_src_reg`. All transfers are non-inverting.
- R4: `b_oe` is active high. Every bit of a section equals that section's `b_drive_en`.
- R5: `a_oe` is active low. Every bit of a section equals the inverse of that section's `a_drive_n`.
- R6: With `b_drive_en`=0 and `a_drive_n`=1, neither bus is driven. Both registers still capture their own bus on their strobes.
- R7: When B is driven live from A and has no external driver, strobing `b_cap` stores the A value in the B register. Strobing both strobes in the same cycle puts the same value in both registers.
- R8: With both directions enabled, both selects live and no external drivers, both buses keep the value they last had. Changes on the undriven inputs have no effect.
- R9: With both directions enabled and both selects stored, `b_out` shows the A register and `a_out` shows the B register in the same cycle.
- R10: A bus bit with no external driver and no internal drive keeps its last seen value. That kept value is what a capture loads.
- R11: The controls of one section affect only that section's bits [s*8 +: 8].
- R12: A synchronous active-low `rst_n` clears both registers and both bus keepers to zero.
- R13: When an external driver and an internal drive are both active on a bus bit, the external value is the one seen and captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_cap | input | NSEC | Per-section strobe that loads the A register from the A bus |
| b_cap | input | NSEC | Per-section strobe that loads the B register from the B bus |
| b_src_reg | input | NSEC | Source for the B bus: 0 live A, 1 A register |
| a_src_reg | input | NSEC | Source for the A bus: 0 live B, 1 B register |
| b_drive_en | input | NSEC | Active-high enable for driving the B bus |
| a_drive_n | input | NSEC | Active-low enable for driving the A bus |
| a_in | input | 16 | External value on the A bus |
| a_in_en | input | 16 | Per-bit flag: an external driver is present on A |
| b_in | input | 16 | External value on the B bus |
| b_in_en | input | 16 | Per-bit flag: an external driver is present on B |
| a_out | output | 16 | Value the block drives onto A |
| a_oe | output | 16 | Per-bit output enable for A |
| b_out | output | 16 | Value the block drives onto B |
| b_oe | output | 16 | Per-bit output enable for B |

## Verification
Two things can happen in the same cycle: a capture strobe, and a live transfer that supplies the very bus being captured. Examples are `b_cap` firing while B is driven live from A, or both strobes firing together. The bench provokes this directly and reads the stored value back through stored-mode outputs. It also keeps doing so in a long random run with mixed drivers and strobes. A behavioural per-bit model, which resolves each bus in priority order, predicts every output on every clock. Captures are judged by the register contents that later appear on the outputs.

// File: rtl/xcvr_pkg.sv
// Package: shared control bundle for one transceiver section.
// Assumes each section is controlled by exactly these six signals.
package xcvr_pkg;

    typedef struct packed {
        logic a_cap;       // load A register from A bus
        logic b_cap;       // load B register from B bus
        logic a_src_reg;   // A bus source: 1 = B register
        logic b_src_reg;   // B bus source: 1 = A register
        logic a_drive_n;   // active-low A drive enable
        logic b_drive_en;  // active-high B drive enable
    } sect_ctrl_t;

endpackage

// File: rtl/bus_keeper.sv
// Bus keeper: remembers the last resolved value of each bus bit.
// Assumes the resolved value is settled before every rising edge.
module bus_keeper #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] seen,
    output logic [W-1:0] held
);

    // Record the bus value each cycle; cleared by reset (R12).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else begin
            held <= seen;
        end
    end

endmodule

// File: rtl/bus_resolver.sv
// Bus resolver: works out the value seen on one bus, bit by bit.
// Priority: external driver, then this block's stored drive, then a
// live drive from the far bus (only when the far bus has a primary
// source), then the keeper. Live-from-far is left out of the primary
// value so that two live directions cannot form a combinational loop.
module bus_resolver #(
    parameter int W = 8
) (
    input  logic [W-1:0] ext_val,
    input  logic [W-1:0] ext_en,
    input  logic         own_reg_drv,
    input  logic [W-1:0] own_reg_val,
    input  logic         far_rt_drv,
    input  logic [W-1:0] far_prim_v,
    input  logic [W-1:0] far_prim,
    input  logic [W-1:0] held,
    output logic [W-1:0] prim_v,
    output logic [W-1:0] prim,
    output logic [W-1:0] seen
);

    logic [W-1:0] rt_m;

    // Primary source: external wins over stored drive (R13).
    always_comb begin
        prim_v = ext_en | {W{own_reg_drv}};
        prim   = (ext_en & ext_val) | (~ext_en & own_reg_val);
    end

    // Final value: primary, else live far bus, else keeper (R8, R10).
    always_comb begin
        rt_m = {W{far_rt_drv}} & far_prim_v & ~prim_v;
        seen = (prim_v & prim) | (rt_m & far_prim) | (~prim_v & ~rt_m & held);
    end

endmodule

// File: rtl/xcvr_section.sv
// One byte-wide transceiver section: two storage registers, two bus
// resolvers and two keepers. Assumes the controls are synchronous to clk.
module xcvr_section
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  sect_ctrl_t   ctl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] a_in_en,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] b_in_en,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    output logic [W-1:0] a_seen,
    output logic [W-1:0] b_seen,
    output logic [W-1:0] a_held,
    output logic [W-1:0] b_held,
    output logic [W-1:0] a_store,
    output logic [W-1:0] b_store
);

    logic         a_on;
    logic         b_on;
    logic [W-1:0] a_pv;
    logic [W-1:0] a_p;
    logic [W-1:0] b_pv;
    logic [W-1:0] b_p;

    assign a_on = ~ctl.a_drive_n;
    assign b_on = ctl.b_drive_en;

    bus_resolver #(.W(W)) a_res_i (
        .ext_val(a_in), .ext_en(a_in_en),
        .own_reg_drv(a_on & ctl.a_src_reg), .own_reg_val(b_store),
        .far_rt_drv(a_on & ~ctl.a_src_reg),
        .far_prim_v(b_pv), .far_prim(b_p), .held(a_held),
        .prim_v(a_pv), .prim(a_p), .seen(a_seen)
    );

    bus_resolver #(.W(W)) b_res_i (
        .ext_val(b_in), .ext_en(b_in_en),
        .own_reg_drv(b_on & ctl.b_src_reg), .own_reg_val(a_store),
        .far_rt_drv(b_on & ~ctl.b_src_reg),
        .far_prim_v(a_pv), .far_prim(a_p), .held(b_held),
        .prim_v(b_pv), .prim(b_p), .seen(b_seen)
    );

    bus_keeper #(.W(W)) a_keep_i (.clk(clk), .rst_n(rst_n), .seen(a_seen), .held(a_held));
    bus_keeper #(.W(W)) b_keep_i (.clk(clk), .rst_n(rst_n), .seen(b_seen), .held(b_held));

    // A register: loads the A bus on its strobe, ignoring select and enable (R1).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_store <= '0;
        end else if (ctl.a_cap) begin
            a_store <= a_seen;
        end
    end

    // B register: loads the B bus on its strobe (R2).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_store <= '0;
        end else if (ctl.b_cap) begin
            b_store <= b_seen;
        end
    end

    // Output data and enables (R3, R4, R5).
    always_comb begin
        b_out = ctl.b_src_reg ? a_store : a_seen;
        a_out = ctl.a_src_reg ? b_store : b_seen;
        b_oe  = {W{b_on}};
        a_oe  = {W{a_on}};
    end

endmodule

// File: rtl/xcvr_regbus.sv
// Top: NSEC independent byte sections placed side by side (R11).
// Assumes every control and data input is synchronous to clk.
module xcvr_regbus
    import xcvr_pkg::*;
#(
    parameter int SEC_W = 8,
    parameter int NSEC  = 2,
    localparam int BW   = SEC_W * NSEC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSEC-1:0] a_cap,
    input  logic [NSEC-1:0] b_cap,
    input  logic [NSEC-1:0] b_src_reg,
    input  logic [NSEC-1:0] a_src_reg,
    input  logic [NSEC-1:0] b_drive_en,
    input  logic [NSEC-1:0] a_drive_n,
    input  logic [BW-1:0]   a_in,
    input  logic [BW-1:0]   a_in_en,
    input  logic [BW-1:0]   b_in,
    input  logic [BW-1:0]   b_in_en,
    output logic [BW-1:0]   a_out,
    output logic [BW-1:0]   a_oe,
    output logic [BW-1:0]   b_out,
    output logic [BW-1:0]   b_oe
);

    logic [BW-1:0] a_seen_all;
    logic [BW-1:0] b_seen_all;
    logic [BW-1:0] a_held_all;
    logic [BW-1:0] b_held_all;
    logic [BW-1:0] a_store_all;
    logic [BW-1:0] b_store_all;

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        sect_ctrl_t ctl;

        // Gather this section's controls into one bundle.
        always_comb begin
            ctl.a_cap      = a_cap[s];
            ctl.b_cap      = b_cap[s];
            ctl.a_src_reg  = a_src_reg[s];
            ctl.b_src_reg  = b_src_reg[s];
            ctl.a_drive_n  = a_drive_n[s];
            ctl.b_drive_en = b_drive_en[s];
        end

        xcvr_section #(.W(SEC_W)) sec_i (
            .clk(clk), .rst_n(rst_n), .ctl(ctl),
            .a_in(a_in[s*SEC_W +: SEC_W]), .a_in_en(a_in_en[s*SEC_W +: SEC_W]),
            .b_in(b_in[s*SEC_W +: SEC_W]), .b_in_en(b_in_en[s*SEC_W +: SEC_W]),
            .a_out(a_out[s*SEC_W +: SEC_W]), .a_oe(a_oe[s*SEC_W +: SEC_W]),
            .b_out(b_out[s*SEC_W +: SEC_W]), .b_oe(b_oe[s*SEC_W +: SEC_W]),
            .a_seen(a_seen_all[s*SEC_W +: SEC_W]), .b_seen(b_seen_all[s*SEC_W +: SEC_W]),
            .a_held(a_held_all[s*SEC_W +: SEC_W]), .b_held(b_held_all[s*SEC_W +: SEC_W]),
            .a_store(a_store_all[s*SEC_W +: SEC_W]), .b_store(b_store_all[s*SEC_W +: SEC_W])
        );
    end

endmodule

// File: rtl/xcvr_regbus_chk.sv
// Checker for xcvr_regbus: temporal properties across registers,
// resolvers and keepers. It is attached to the top by the bind below.
module xcvr_regbus_chk #(
    parameter int SEC_W = 8,
    parameter int NSEC  = 2,
    localparam int BW   = SEC_W * NSEC
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSEC-1:0] a_cap,
    input logic [NSEC-1:0] b_cap,
    input logic [NSEC-1:0] b_src_reg,
    input logic [NSEC-1:0] a_src_reg,
    input logic [NSEC-1:0] b_drive_en,
    input logic [NSEC-1:0] a_drive_n,
    input logic [BW-1:0]   a_in_en,
    input logic [BW-1:0]   b_in_en,
    input logic [BW-1:0]   a_out,
    input logic [BW-1:0]   b_out,
    input logic [BW-1:0]   a_seen_all,
    input logic [BW-1:0]   b_seen_all,
    input logic [BW-1:0]   a_held_all,
    input logic [BW-1:0]   b_held_all,
    input logic [BW-1:0]   a_store_all,
    input logic [BW-1:0]   b_store_all
);

    // A reset cycle clears both registers (R12).
    p_reset_clear_r12: assert property (@(posedge clk)
        !rst_n |=> (a_store_all == '0 && b_store_all == '0));

    for (genvar s = 0; s < NSEC; s++) begin : g_chk
        localparam int L = s * SEC_W;

        // A strobe loads the bus value from the previous cycle (R1).
        p_a_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
            a_cap[s] |=> a_store_all[L +: SEC_W] == $past(a_seen_all[L +: SEC_W]));

        // With no A strobe, the A register holds its value (R1).
        p_a_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !a_cap[s] |=> $stable(a_store_all[L +: SEC_W]));

        // A B strobe loads the B bus value (R2).
        p_b_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
            b_cap[s] |=> b_store_all[L +: SEC_W] == $past(b_seen_all[L +: SEC_W]));

        // In stored mode, B carries the A register (R3).
        p_b_stored_r3: assert property (@(posedge clk) disable iff (!rst_n)
            b_src_reg[s] |-> b_out[L +: SEC_W] == a_store_all[L +: SEC_W]);

        // In live mode, A carries the resolved B bus (R3).
        p_a_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !a_src_reg[s] |-> a_out[L +: SEC_W] == b_seen_all[L +: SEC_W]);

        // In the mutual live latch, both buses show their keepers (R8).
        p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (b_drive_en[s] && !a_drive_n[s] && !b_src_reg[s] && !a_src_reg[s]
             && a_in_en[L +: SEC_W] == '0 && b_in_en[L +: SEC_W] == '0)
            |-> (a_seen_all[L +: SEC_W] == a_held_all[L +: SEC_W]
                 && b_seen_all[L +: SEC_W] == b_held_all[L +: SEC_W]));

        // An undriven, unsourced A bus reads back its keeper (R10).
        p_a_bushold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (a_drive_n[s] && a_in_en[L +: SEC_W] == '0)
            |-> a_seen_all[L +: SEC_W] == a_held_all[L +: SEC_W]);
    end

endmodule

bind xcvr_regbus xcvr_regbus_chk #(.SEC_W(SEC_W), .NSEC(NSEC)) chk_i (.*);

// File: tb/xcvr_regbus_tb_top.sv
// Bench for xcvr_regbus: a behavioural per-bit model compared on every
// clock, plus directed checks with literal expected values.
module xcvr_regbus_tb_top;

    localparam int SW = 8;
    localparam int NS = 2;
    localparam int BW = SW * NS;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NS-1:0] a_cap, b_cap, b_src_reg, a_src_reg, b_drive_en, a_drive_n;
    logic [BW-1:0] a_in, a_in_en, b_in, b_in_en;
    logic [BW-1:0] a_out, a_oe, b_out, b_oe;

    int total = 0;
    int bad   = 0;

    // Model state and the values it predicts.
    logic [BW-1:0] m_ra, m_rb, m_ah, m_bh;
    logic [BW-1:0] m_as, m_bs, m_ao, m_bo, m_aoe, m_boe;

    always #5 clk = ~clk;

    xcvr_regbus #(.SEC_W(SW), .NSEC(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .a_cap(a_cap), .b_cap(b_cap),
        .b_src_reg(b_src_reg), .a_src_reg(a_src_reg),
        .b_drive_en(b_drive_en), .a_drive_n(a_drive_n),
        .a_in(a_in), .a_in_en(a_in_en), .b_in(b_in), .b_in_en(b_in_en),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    // Model: resolve every bus bit through a priority chain.
    always_comb begin
        for (int i = 0; i < BW; i++) begin
            int  s;
            bit  a_int, b_int, bpv, bp, apv, ap;
            s     = i / SW;
            a_int = !a_drive_n[s];
            b_int = b_drive_en[s];
            apv = 1'b0; ap = 1'b0; bpv = 1'b0; bp = 1'b0;
            if (a_in_en[i]) begin apv = 1'b1; ap = a_in[i]; end
            else if (a_int && a_src_reg[s]) begin apv = 1'b1; ap = m_rb[i]; end
            if (b_in_en[i]) begin bpv = 1'b1; bp = b_in[i]; end
            else if (b_int && b_src_reg[s]) begin bpv = 1'b1; bp = m_ra[i]; end
            if (apv) m_as[i] = ap;
            else if (a_int && !a_src_reg[s] && bpv) m_as[i] = bp;
            else m_as[i] = m_ah[i];
            if (bpv) m_bs[i] = bp;
            else if (b_int && !b_src_reg[s] && apv) m_bs[i] = ap;
            else m_bs[i] = m_bh[i];
            m_ao[i]  = a_src_reg[s] ? m_rb[i] : m_bs[i];
            m_bo[i]  = b_src_reg[s] ? m_ra[i] : m_as[i];
            m_aoe[i] = a_int;
            m_boe[i] = b_int;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One clock: compare all outputs mid-low-phase, then step the model.
    task automatic cycle(input string req);
        logic [BW-1:0] na, nb;
        @(negedge clk);
        #1;
        chk(req, "a_out", a_out, m_ao);
        chk(req, "b_out", b_out, m_bo);
        chk(req, "a_oe", a_oe, m_aoe);
        chk(req, "b_oe", b_oe, m_boe);
        na = m_as;
        nb = m_bs;
        @(posedge clk);
        if (!rst_n) begin
            m_ra = '0; m_rb = '0; m_ah = '0; m_bh = '0;
        end else begin
            for (int i = 0; i < BW; i++) begin
                if (a_cap[i / SW]) m_ra[i] = na[i];
                if (b_cap[i / SW]) m_rb[i] = nb[i];
            end
            m_ah = na;
            m_bh = nb;
        end
        #1;
    endtask

    task automatic idle();
        a_cap = '0; b_cap = '0; a_src_reg = '0; b_src_reg = '0;
        b_drive_en = '0; a_drive_n = '1; a_in_en = '0; b_in_en = '0;
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_ra = '0; m_rb = '0; m_ah = '0; m_bh = '0;
        idle();
        a_in = '0; b_in = '0;
        rst_n = 1'b0;
        #1;
        cycle("R12"); cycle("R12");
        rst_n = 1'b1;
        // R12: after reset the stored registers read back as zero.
        a_drive_n = '0; a_src_reg = '1; b_drive_en = '1; b_src_reg = '1;
        #1;
        chk("R12", "a_out reset", a_out, 16'h0000);
        chk("R12", "b_out reset", b_out, 16'h0000);
        cycle("R12");

        // R6: isolated, both strobes still capture.
        idle();
        a_in = 16'hA55A; a_in_en = '1; b_in = 16'h3CC3; b_in_en = '1;
        a_cap = '1; b_cap = '1;
        cycle("R6");
        idle();
        b_drive_en = '1; b_src_reg = '1; a_drive_n = '0; a_src_reg = '1;
        #1;
        chk("R1", "b_out stored A", b_out, 16'hA55A);
        chk("R2", "a_out stored B", a_out, 16'h3CC3);
        chk("R4", "b_oe on", b_oe, 16'hFFFF);
        chk("R5", "a_oe on", a_oe, 16'hFFFF);
        cycle("R6");

        // R3: live A to B follows within the same cycle.
        idle();
        b_drive_en = '1; a_in_en = '1; a_in = 16'h1234;
        #1;
        chk("R3", "b_out live", b_out, 16'h1234);
        a_in = 16'h4321;
        #1;
        chk("R3", "b_out live 2", b_out, 16'h4321);
        cycle("R3");

        // R4, R5: polarity and per-section enables.
        idle();
        a_drive_n = 2'b01;
        #1;
        chk("R4", "b_oe off", b_oe, 16'h0000);
        chk("R5", "a_oe upper", a_oe, 16'hFF00);
        cycle("R5");

        // R7: pass-through from A into both registers in one cycle.
        idle();
        a_in = 16'h5AA5; a_in_en = '1; b_drive_en = '1;
        a_cap = '1; b_cap = '1;
        cycle("R7");
        idle();
        a_drive_n = '0; a_src_reg = '1; b_drive_en = '1; b_src_reg = '1;
        #1;
        chk("R7", "B register", a_out, 16'h5AA5);
        chk("R7", "A register", b_out, 16'h5AA5);
        cycle("R7");

        // R8: mutual live latch keeps the last value.
        idle();
        a_in = 16'hC33C; a_in_en = '1; b_drive_en = '1;
        cycle("R8");
        a_in_en = '0; a_drive_n = '0;
        cycle("R8"); cycle("R8");
        a_in = 16'h0000; b_in = 16'hFFFF;
        #1;
        chk("R8", "a_out latched", a_out, 16'hC33C);
        chk("R8", "b_out latched", b_out, 16'hC33C);
        cycle("R8");

        // R9: both directions stored at once.
        idle();
        a_in = 16'h1111; a_in_en = '1; b_in = 16'h2222; b_in_en = '1;
        a_cap = '1; b_cap = '1;
        cycle("R9");
        idle();
        a_drive_n = '0; a_src_reg = '1; b_drive_en = '1; b_src_reg = '1;
        #1;
        chk("R9", "b_out", b_out, 16'h1111);
        chk("R9", "a_out", a_out, 16'h2222);
        cycle("R9");

        // R10: kept value on an undriven bus is what gets captured.
        idle();
        a_in = 16'h7E7E; a_in_en = '1;
        cycle("R10");
        a_in_en = '0; a_in = 16'h0000;
        cycle("R10");
        a_cap = '1;
        cycle("R10");
        idle();
        b_drive_en = '1; b_src_reg = '1;
        #1;
        chk("R10", "kept capture", b_out, 16'h7E7E);
        cycle("R10");

        // R11: a strobe in section 0 leaves section 1 untouched.
        idle();
        a_in = 16'hABCD; a_in_en = '1; a_cap = 2'b01;
        cycle("R11");
        idle();
        b_drive_en = 2'b01; b_src_reg = '1;
        #1;
        chk("R11", "b_oe low only", b_oe, 16'h00FF);
        chk("R11", "b_out sections", b_out, 16'h7ECD);
        cycle("R11");

        // R13: external driver beats stored drive on A.
        idle();
        a_drive_n = '0; a_src_reg = '1; a_in = 16'h0F0F; a_in_en = '1; a_cap = '1;
        cycle("R13");
        idle();
        b_drive_en = '1; b_src_reg = '1;
        #1;
        chk("R13", "external wins", b_out, 16'h0F0F);
        cycle("R13");

        // Random mix of all controls, compared with the model every clock.
        for (int n = 0; n < 600; n++) begin
            a_cap      = NS'($urandom);
            b_cap      = NS'($urandom);
            a_src_reg  = NS'($urandom);
            b_src_reg  = NS'($urandom);
            a_drive_n  = NS'($urandom);
            b_drive_en = NS'($urandom);
            a_in       = BW'($urandom);
            b_in       = BW'($urandom);
            a_in_en    = BW'($urandom) & BW'($urandom);
            b_in_en    = BW'($urandom) & BW'($urandom);
            rst_n      = ($urandom % 97) != 0;
            cycle("R3");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule